// File: doc/BRIEF.md
# Inter-Processor Interrupt Destination Decoder

This block sits behind the command register of one processor's interrupt controller and turns a command write into a delivery request for a group of up to eight processors. The command register has two 32-bit halves. Writing the upper half only records the destination byte. Writing the lower half records the command and launches it. One clock after the launching write, the block gives a single-cycle strobe. The strobe carries a processor mask, the vector, the delivery mode and the level and trigger bits. Per-processor injection logic downstream consumes this strobe.

The mask comes from one of several sources: the two-bit shorthand field, the physical destination rule (a single processor ID or a broadcast), or the logical rule, which overlaps the destination byte with each processor's logical destination byte. Processor IDs are fixed and equal to the processor's index. Lowest-priority requests are aimed at the sender itself. An INIT command with level clear and trigger set is a de-assert. It delivers nothing and only pulses an arbitration-resynchronise strobe. Any other INIT is sent to every processor. System-management, startup and reserved modes are dropped.

Top module: `ipi_dest_decoder`

## Requirements
- R1: A write to index 0x31 (upper half) stores bits 31:24 as the destination byte and raises neither `dlvValid` nor `arbSync` in the following cycle.
- R2: A write to index 0x30 (lower half) with a delivering mode raises `dlvValid` for exactly the next cycle, with `dlvVector`=bits 7:0, `dlvMode`=bits 10:8, `dlvLevel`=bit 14 and `dlvTrigger`=bit 15 of that write. The destination used is the byte most recently stored by R1.
- R3: With shorthand (bits 19:18) equal to 0 and bit 11 clear (physical), destination 0xFF sets every mask bit. Any other destination sets only the bit of the processor whose ID equals it, and a destination of NCPU or above gives an empty mask.
- R4: With shorthand 0 and bit 11 set (logical), mask bit i is set exactly when the destination byte ANDed with `logDest[8*i+7:8*i]` is nonzero.
- R5: Shorthand 1 selects only processor `selfId`, shorthand 2 selects all processors, and shorthand 3 selects all except `selfId`; the destination byte has no effect.
- R6: In mode 1 (lowest priority) the destination byte is replaced by `selfId` before decoding.
- R7: Mode 5 (INIT) with bit 14 = 0 and bit 15 = 1 pulses `arbSync` for one cycle and leaves `dlvValid` low.
- R8: Any other mode-5 command gives `dlvValid` with `dlvMode`=5 and every mask bit set, whatever the shorthand and destination.
- R9: Modes 0, 1, 4 and 7 deliver; modes 2, 3 and 6 produce neither `dlvValid` nor `arbSync`.
- R10: While `rstN` is low all outputs are zero and the stored destination byte clears to 0x00.
- R11: Writes with `wrEn` low, or to any index other than 0x30 and 0x31, produce no strobe and leave the stored destination byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write enable |
| wrAddr | input | ADDR_W | Register index of the write |
| wrData | input | 32 | Write data |
| selfId | input | ID_W | ID of the sending processor |
| logDest | input | 8*NCPU | Logical destination byte of each processor, processor i at bits 8i+7:8i |
| dlvValid | output | 1 | One-cycle delivery strobe |
| dlvMask | output | NCPU | Selected processors |
| dlvVector | output | 8 | Vector of the delivery |
| dlvMode | output | 3 | Delivery mode of the delivery |
| dlvLevel | output | 1 | Level bit of the delivery |
| dlvTrigger | output | 1 | Trigger bit of the delivery |
| arbSync | output | 1 | One-cycle arbitration-resynchronise strobe |

## Verification
The physical rule is tried with a single ID, the broadcast byte and an out-of-range ID. These separate the one-hot, all-ones and empty-mask outcomes. The logical rule uses logical bytes that overlap, so one destination bit selects two processors, which an ID-based decode would not do. Each shorthand is sent with a stored destination that would choose a different mask, so a shorthand that leaked the destination would show. INIT is sent in both level/trigger combinations and every unsupported mode is sent between delivering commands. Ignored writes are followed by a launch whose mask exposes the stored destination byte.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

  typedef enum logic [2:0] {
    DM_FIXED   = 3'd0,
    DM_LOWPRI  = 3'd1,
    DM_SMM     = 3'd2,
    DM_RSVD    = 3'd3,
    DM_NMI     = 3'd4,
    DM_INIT    = 3'd5,
    DM_STARTUP = 3'd6,
    DM_EXTINT  = 3'd7
  } dlvMode_e;

  typedef enum logic [1:0] {
    SH_DEST   = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } shorthand_e;

  // Strobes from the control decode to the datapath
  typedef struct packed {
    logic loadHi;   // store destination byte
    logic launch;   // deliver with the decoded mask
    logic initAll;  // deliver INIT to every processor
    logic arbSync;  // INIT de-assert: resynchronise only
  } ctrlStb_t;

endpackage

// File: rtl/ipi_ctrl.sv
module ipi_ctrl
  import ipi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] IDX_LO = 'h30,
  parameter logic [ADDR_W-1:0] IDX_HI = 'h31
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [2:0]        cmdMode,
  input  logic              cmdLevel,
  input  logic              cmdTrigger,
  output ctrlStb_t          stb
);

  logic hitLo;
  logic canDeliver;
  logic isInit;
  logic initDeassert;

  always_comb begin
    hitLo = wrEn && (wrAddr == IDX_LO);
    unique case (dlvMode_e'(cmdMode))
      DM_FIXED, DM_LOWPRI, DM_NMI, DM_EXTINT: canDeliver = 1'b1;
      default:                                 canDeliver = 1'b0;
    endcase
    isInit       = (dlvMode_e'(cmdMode) == DM_INIT);
    initDeassert = isInit && !cmdLevel && cmdTrigger;

    stb.loadHi  = wrEn && (wrAddr == IDX_HI);
    stb.launch  = hitLo && canDeliver;
    stb.initAll = hitLo && isInit && !initDeassert;
    stb.arbSync = hitLo && initDeassert;
  end

endmodule

// File: rtl/ipi_datapath.sv
module ipi_datapath
  import ipi_pkg::*;
#(
  parameter int NCPU = 8,
  parameter int ID_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic [31:0]       wrData,
  input  logic [ID_W-1:0]   selfId,
  input  logic [8*NCPU-1:0] logDest,
  output logic              dlvValid,
  output logic [NCPU-1:0]   dlvMask,
  output logic [7:0]        dlvVector,
  output logic [2:0]        dlvMode,
  output logic              dlvLevel,
  output logic              dlvTrigger,
  output logic              arbSync
);

  logic [7:0]      hiDest;
  logic [7:0]      effDest;
  logic [1:0]      cmdShort;
  logic            cmdLogical;
  logic [NCPU-1:0] hit;
  logic            unusedBits;

  assign cmdShort   = wrData[19:18];
  assign cmdLogical = wrData[11];
  assign unusedBits = ^{wrData[23:20], wrData[17:16], wrData[13:12]};

  // Lowest priority aims at the sender's own ID
  assign effDest = (dlvMode_e'(wrData[10:8]) == DM_LOWPRI) ? 8'(selfId) : hiDest;

  for (genvar i = 0; i < NCPU; i++) begin : g_cpu
    localparam logic [7:0]      MY_ID  = 8'(i);
    localparam logic [ID_W-1:0] MY_IDX = ID_W'(i);
    logic [7:0] myLog;
    assign myLog = logDest[8*i +: 8];

    always_comb begin
      unique case (shorthand_e'(cmdShort))
        SH_DEST:
          if (cmdLogical) hit[i] = |(effDest & myLog);
          else            hit[i] = (effDest == 8'hFF) || (effDest == MY_ID);
        SH_SELF:   hit[i] = (selfId == MY_IDX);
        SH_ALL:    hit[i] = 1'b1;
        SH_OTHERS: hit[i] = (selfId != MY_IDX);
        default:   hit[i] = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiDest     <= '0;
      dlvValid   <= 1'b0;
      dlvMask    <= '0;
      dlvVector  <= '0;
      dlvMode    <= '0;
      dlvLevel   <= 1'b0;
      dlvTrigger <= 1'b0;
      arbSync    <= 1'b0;
    end else begin
      if (stb.loadHi) hiDest <= wrData[31:24];
      dlvValid <= stb.launch || stb.initAll;
      arbSync  <= stb.arbSync;
      if (stb.launch || stb.initAll) begin
        dlvMask    <= stb.initAll ? '1 : hit;
        dlvVector  <= wrData[7:0];
        dlvMode    <= wrData[10:8];
        dlvLevel   <= wrData[14];
        dlvTrigger <= wrData[15];
      end
    end
  end

endmodule

// File: rtl/ipi_dest_decoder.sv
module ipi_dest_decoder
  import ipi_pkg::*;
#(
  parameter int NCPU   = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] IDX_LO = 'h30,
  parameter logic [ADDR_W-1:0] IDX_HI = 'h31,
  localparam int ID_W  = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  input  logic [ID_W-1:0]   selfId,
  input  logic [8*NCPU-1:0] logDest,
  output logic              dlvValid,
  output logic [NCPU-1:0]   dlvMask,
  output logic [7:0]        dlvVector,
  output logic [2:0]        dlvMode,
  output logic              dlvLevel,
  output logic              dlvTrigger,
  output logic              arbSync
);

  ctrlStb_t stb;

  ipi_ctrl #(
    .ADDR_W(ADDR_W), .IDX_LO(IDX_LO), .IDX_HI(IDX_HI)
  ) u_ctrl (
    .wrEn(wrEn), .wrAddr(wrAddr), .cmdMode(wrData[10:8]),
    .cmdLevel(wrData[14]), .cmdTrigger(wrData[15]), .stb(stb)
  );

  ipi_datapath #(
    .NCPU(NCPU), .ID_W(ID_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .selfId(selfId),
    .logDest(logDest), .dlvValid(dlvValid), .dlvMask(dlvMask),
    .dlvVector(dlvVector), .dlvMode(dlvMode), .dlvLevel(dlvLevel),
    .dlvTrigger(dlvTrigger), .arbSync(arbSync)
  );

endmodule

// File: rtl/ipi_dest_checker.sv
module ipi_dest_checker #(
  parameter int NCPU   = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] IDX_LO = 'h30,
  parameter logic [ADDR_W-1:0] IDX_HI = 'h31,
  parameter int ID_W   = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [31:0]       wrData,
  input logic [ID_W-1:0]   selfId,
  input logic              dlvValid,
  input logic [NCPU-1:0]   dlvMask,
  input logic [2:0]        dlvMode,
  input logic              arbSync
);

  logic lo;
  assign lo = wrEn && (wrAddr == IDX_LO);

  AST_HI_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == IDX_HI) |=> (!dlvValid && !arbSync)); // R1

  AST_STROBE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    dlvValid |-> $past(lo)); // R2

  AST_SELF_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    (lo && wrData[19:18] == 2'd1 && wrData[10:8] == 3'd0)
      |=> (dlvValid && $countones(dlvMask) == 1)); // R5

  AST_OTHERS_SKIP_SELF: assert property (@(posedge clk) disable iff (!rstN)
    (lo && wrData[19:18] == 2'd3 && wrData[10:8] == 3'd0)
      |=> (dlvValid && dlvMask[$past(selfId)] == 1'b0)); // R5

  AST_INIT_DEASSERT: assert property (@(posedge clk) disable iff (!rstN)
    (lo && wrData[10:8] == 3'd5 && !wrData[14] && wrData[15])
      |=> (arbSync && !dlvValid)); // R7

  AST_INIT_ALL: assert property (@(posedge clk) disable iff (!rstN)
    (dlvValid && dlvMode == 3'd5) |-> (&dlvMask)); // R8

  AST_UNSUP_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (lo && (wrData[10:8] == 3'd2 || wrData[10:8] == 3'd3 || wrData[10:8] == 3'd6))
      |=> (!dlvValid && !arbSync)); // R9

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rstN |=> (!dlvValid && !arbSync && dlvMask == '0)); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> (!dlvValid && !arbSync)); // R11

endmodule

bind ipi_dest_decoder ipi_dest_checker #(
  .NCPU(NCPU), .ADDR_W(ADDR_W), .IDX_LO(IDX_LO), .IDX_HI(IDX_HI), .ID_W(ID_W)
) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .selfId(selfId), .dlvValid(dlvValid), .dlvMask(dlvMask),
  .dlvMode(dlvMode), .arbSync(arbSync)
);

// File: tb/ipi_dest_decoder_tb.sv
module ipi_dest_decoder_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NCPU = 8;
  localparam int WATCHDOG = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [2:0]  selfId = 3'd3;
  logic [8*NCPU-1:0] logDest;
  logic        dlvValid, dlvLevel, dlvTrigger, arbSync;
  logic [NCPU-1:0] dlvMask;
  logic [7:0]  dlvVector;
  logic [2:0]  dlvMode;

  // logical bytes: cpu7..cpu0 ; cpu3 overlaps cpu2 on bit 2
  assign logDest = {8'h80, 8'h40, 8'h20, 8'h10, 8'h0C, 8'h04, 8'h02, 8'h01};

  always #(CLK_PERIOD/2) clk = ~clk;

  ipi_dest_decoder u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .selfId(selfId), .logDest(logDest), .dlvValid(dlvValid), .dlvMask(dlvMask),
    .dlvVector(dlvVector), .dlvMode(dlvMode), .dlvLevel(dlvLevel),
    .dlvTrigger(dlvTrigger), .arbSync(arbSync)
  );

  typedef struct {
    bit       v;
    bit       a;
    bit [7:0] mask;
    bit [7:0] vec;
    bit [2:0] mode;
    bit       l;
    bit       t;
    int       req;
  } expItem_t;

  expItem_t q[$];
  int checks = 0;
  int fails = 0;
  bit [7:0] benchHi = 8'h00;
  bit driverDone = 0;

  function automatic bit [31:0] lowWord(bit [1:0] sh, bit trg, bit lvl,
                                        bit logical, bit [2:0] mode, bit [7:0] vec);
    return {12'h0, sh, 2'b0, trg, lvl, 2'b0, logical, mode, vec};
  endfunction

  function automatic expItem_t model(bit [31:0] d, int req);
    expItem_t e;
    bit [7:0] dst;
    e = '{v:0, a:0, mask:0, vec:d[7:0], mode:d[10:8], l:d[14], t:d[15], req:req};
    if (d[10:8] == 3'd2 || d[10:8] == 3'd3 || d[10:8] == 3'd6) return e;
    if (d[10:8] == 3'd5) begin
      if (!d[14] && d[15]) e.a = 1;
      else begin e.v = 1; e.mask = 8'hFF; end
      return e;
    end
    e.v = 1;
    dst = (d[10:8] == 3'd1) ? 8'(selfId) : benchHi;
    for (int i = 0; i < NCPU; i++) begin
      case (d[19:18])
        2'd0: e.mask[i] = d[11] ? |(dst & logDest[8*i +: 8])
                                : (dst == 8'hFF || dst == 8'(i));
        2'd1: e.mask[i] = (3'(i) == selfId);
        2'd2: e.mask[i] = 1'b1;
        default: e.mask[i] = (3'(i) != selfId);
      endcase
    end
    return e;
  endfunction

  // driver: one write, expected item pushed after the capturing edge
  task automatic wr(bit en, bit [7:0] addr, bit [31:0] d, int req);
    expItem_t e;
    @(negedge clk);
    wrEn = en; wrAddr = addr; wrData = d;
    @(posedge clk);
    if (en && addr == 8'h30) e = model(d, req);
    else e = '{v:0, a:0, mask:0, vec:0, mode:0, l:0, t:0, req:req};
    if (en && addr == 8'h31) benchHi = d[31:24];
    q.push_back(e);
    #1 wrEn = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rstN && q.size() > 0) begin
      expItem_t e;
      e = q.pop_front();
      checks++;
      if (e.v) begin
        if (!(dlvValid && !arbSync && dlvMask == e.mask && dlvVector == e.vec &&
              dlvMode == e.mode && dlvLevel == e.l && dlvTrigger == e.t)) begin
          fails++;
          $display("FAIL R%0d: actual v=%b a=%b mask=%h vec=%h mode=%0d l=%b t=%b expected v=1 a=0 mask=%h vec=%h mode=%0d l=%b t=%b",
                   e.req, dlvValid, arbSync, dlvMask, dlvVector, dlvMode, dlvLevel, dlvTrigger,
                   e.mask, e.vec, e.mode, e.l, e.t);
        end
      end else if (dlvValid !== 1'b0 || arbSync !== e.a) begin
        fails++;
        $display("FAIL R%0d: actual v=%b a=%b expected v=0 a=%b",
                 e.req, dlvValid, arbSync, e.a);
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!driverDone && cyc < WATCHDOG) begin @(posedge clk); cyc++; end
    if (!driverDone) begin
      fails++;
      $display("FAIL watchdog: actual=hung after %0d cycles expected=completion", cyc);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++; // R10 reset state
    if (dlvValid || arbSync || dlvMask != 0 || dlvVector != 0) begin
      fails++;
      $display("FAIL R10: actual v=%b a=%b mask=%h vec=%h expected all zero",
               dlvValid, arbSync, dlvMask, dlvVector);
    end
    rstN = 1'b1;
    // R10: stored destination cleared, physical dest 0 -> cpu0
    wr(1, 8'h30, lowWord(0, 0, 0, 0, 3'd0, 8'h20), 10);
    wr(1, 8'h31, 32'h0500_0000, 1);                        // R1
    wr(1, 8'h30, lowWord(0, 1, 1, 0, 3'd0, 8'h41), 2);     // R2 R3 -> 0x20
    wr(1, 8'h31, 32'hFF00_0000, 1);                        // R1
    wr(1, 8'h30, lowWord(0, 0, 1, 0, 3'd0, 8'h42), 3);     // R3 broadcast
    wr(1, 8'h31, 32'h0900_0000, 1);
    wr(1, 8'h30, lowWord(0, 0, 0, 0, 3'd0, 8'h43), 3);     // R3 out of range
    wr(1, 8'h31, 32'h0400_0000, 1);
    wr(1, 8'h30, lowWord(0, 0, 0, 1, 3'd0, 8'h44), 4);     // R4 overlap -> 0x0C
    wr(1, 8'h31, 32'h3000_0000, 1);
    wr(1, 8'h30, lowWord(0, 1, 0, 1, 3'd0, 8'h45), 4);     // R4 -> 0x30
    wr(1, 8'h30, lowWord(1, 0, 0, 0, 3'd0, 8'h46), 5);     // R5 self
    wr(1, 8'h30, lowWord(2, 0, 0, 1, 3'd0, 8'h47), 5);     // R5 all
    wr(1, 8'h30, lowWord(3, 0, 0, 0, 3'd0, 8'h48), 5);     // R5 others
    wr(1, 8'h31, 32'h0600_0000, 1);
    wr(1, 8'h30, lowWord(0, 0, 0, 0, 3'd1, 8'h49), 6);     // R6 lowest prio
    selfId = 3'd6;
    wr(1, 8'h30, lowWord(0, 0, 0, 0, 3'd1, 8'h4A), 6);     // R6 with new sender
    wr(1, 8'h30, lowWord(0, 0, 0, 0, 3'd4, 8'h02), 9);     // R9 NMI
    wr(1, 8'h30, lowWord(0, 0, 0, 0, 3'd7, 8'h00), 9);     // R9 external
    wr(1, 8'h30, lowWord(0, 1, 0, 0, 3'd5, 8'h00), 7);     // R7 de-assert
    wr(1, 8'h30, lowWord(1, 0, 1, 0, 3'd5, 8'h00), 8);     // R8 INIT
    wr(1, 8'h30, lowWord(0, 1, 1, 0, 3'd5, 8'h00), 8);     // R8 INIT
    wr(1, 8'h30, lowWord(0, 0, 0, 0, 3'd2, 8'h50), 9);     // R9 drop
    wr(1, 8'h30, lowWord(0, 0, 0, 0, 3'd3, 8'h51), 9);     // R9 drop
    wr(1, 8'h30, lowWord(2, 0, 0, 0, 3'd6, 8'h52), 9);     // R9 drop
    wr(1, 8'h20, 32'hFF00_0000, 11);                       // R11 other index
    wr(0, 8'h31, 32'h0100_0000, 11);                       // R11 disabled
    wr(0, 8'h30, lowWord(2, 0, 0, 0, 3'd0, 8'h53), 11);    // R11 disabled launch
    wr(1, 8'h30, lowWord(0, 0, 0, 0, 3'd0, 8'h54), 11);    // R11 dest still 0x06
    @(negedge clk);
    @(negedge clk);
    driverDone = 1;
  end

endmodule